// File: doc/BRIEF.md
# Stereo Audio Codec Clock Generator and Serial Frame Master

This block builds the whole clock set for an external audio converter from one fixed master clock. It then runs the stereo serial link to that converter as the frame master. A programmable integer divisor gives the converter system rate. From that rate the block makes a bit clock at one quarter of it, and a left/right frame clock at 1/256 of it. Each stereo frame therefore carries 64 bit clocks, 32 for each channel. With a 12.288 MHz master clock, a divisor of 4 gives a 12 kHz sample rate and a divisor of 6 gives 8 kHz.

Two parallel sample words, one left and one right, are serialised MSB first. Framing is the common inter-chip sound convention: the first bit clock after every frame-clock edge is empty, and the MSB follows in the second slot. Returned serial data is collected into parallel words. Two one-cycle pulses mark the word edges: one when a received word is complete, and one when the last bit of an outgoing word has left the transmit shifter. Word length is 16 or 20 bits. The divisor and the word length are taken up only at a frame start, so a frame in flight is never torn.

Top module: `aud_link_master`

## Requirements
- R1: `sysclk_en` is high for one master cycle in every N master cycles. N is `div_n` limited to the range 1..8: a value of 0 counts as 1 and values above 8 count as 8. It therefore pulses exactly 256 times per stereo frame.
- R2: `bclk` has a period of 4N master cycles and `lrclk` has a period of 256N master cycles (64 bit clocks).
- R3: `lrclk` is low for the left half and high for the right half, and each half lasts 128N master cycles. It changes only together with a falling `bclk` edge.
- R4: In each half, slot 0 (the first bit clock after the `lrclk` edge) carries 0. Slots 1..W carry the word MSB first, and slots W+1..31 carry 0. W is 20 when the word length select is 1 and 16 when it is 0.
- R5: The left half carries `tx_left` and the right half carries `tx_right`. Each word is sampled at the clock edge that starts its half. Words are right-aligned in the 20-bit ports, so 16-bit mode sends bits 15:0.
- R6: `sdout` changes only on the master edge on which `bclk` falls. `sdin` is sampled on the master edge on which `bclk` rises.
- R7: `rx_ready` is a one-cycle pulse that follows the rising `bclk` edge carrying a word's LSB. With it, `rx_data` holds the word right-aligned, with bits 19:16 zero in 16-bit mode, and `rx_right` is 1 for the right word.
- R8: `tx_ready` is a one-cycle pulse that follows the falling `bclk` edge ending the LSB slot. This is exactly 2N master cycles after the matching `rx_ready`, and there are two pulses per frame.
- R9: A change of `div_n` or `word20` during a frame leaves that frame unchanged. The new values take effect at the next falling `lrclk` edge.
- R10: Receive ignores `sdin` in slot 0 and in slots after the LSB. `rx_data` changes only together with `rx_ready`.
- R11: During reset `bclk` and `lrclk` are high and `sdout`, `tx_ready`, `rx_ready` and `rx_data` are zero. The first master edge after reset starts a left half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_n | input | 4 | Requested system-rate divisor N |
| word20 | input | 1 | Word length select: 1 = 20 bits, 0 = 16 bits |
| tx_left | input | 20 | Left sample to send, right-aligned |
| tx_right | input | 20 | Right sample to send, right-aligned |
| sdin | input | 1 | Serial data returned from the converter |
| sysclk_en | output | 1 | Converter system-rate strobe, one master cycle wide |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock, low = left |
| sdout | output | 1 | Serial data to the converter |
| tx_ready | output | 1 | Pulse: outgoing word fully shifted out |
| rx_ready | output | 1 | Pulse: received word complete |
| rx_right | output | 1 | Channel of the word in rx_data, 1 = right |
| rx_data | output | 20 | Last received word, right-aligned |

## Verification
A wrong divider or phase count shows up within one frame as a frame length other than 256N cycles, or as a count of system strobes other than 256. A wrong slot count or a missing empty slot misplaces every serial bit in the next half frame. That appears both in the captured `sdout` slot pattern and in the looped-back word. Latching the divisor or word length outside the frame start stretches or truncates the frame in which the change was made. The bench also forces ones onto `sdin` in the slots that must be ignored, so that any sampling outside the word shows up in the very next received word.

// File: rtl/aud_link_pkg.sv
package aud_link_pkg;
  localparam int unsigned DIV_W      = 4;
  localparam int unsigned DIV_MAX    = 8;
  localparam int unsigned WORD_MAX   = 20;
  localparam int unsigned SHORT_BITS = 16;
  localparam int unsigned BCLK_RATIO = 4;
  localparam int unsigned HALF_SLOTS = 32;

  // Bits per word for the selected length.
  function automatic int unsigned word_bits(input logic long_mode);
    return long_mode ? WORD_MAX : SHORT_BITS;
  endfunction

  // Requested divisor forced into 1..hi.
  function automatic int unsigned clamp_div(input int unsigned d, input int unsigned hi);
    if (d == 0) return 1;
    if (d > hi) return hi;
    return d;
  endfunction
endpackage

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_link_pkg::*;
#(
  parameter int unsigned P_DIV_W   = DIV_W,
  parameter int unsigned P_DIV_MAX = DIV_MAX,
  parameter int unsigned P_RATIO   = BCLK_RATIO,
  parameter int unsigned P_HALF    = HALF_SLOTS,
  localparam int unsigned PH_W     = $clog2(P_RATIO),
  localparam int unsigned SLOT_W   = $clog2(2 * P_HALF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [P_DIV_W-1:0] div_req,
  input  logic              w20_req,
  output logic              sys_tick,
  output logic              bit_rise,
  output logic              bit_fall,
  output logic [SLOT_W-1:0] slot,
  output logic              act_w20,
  output logic              load_w20,
  output logic              bclk,
  output logic              lrclk
);
  logic [P_DIV_W-1:0] cnt;
  logic [P_DIV_W-1:0] act_n;
  logic [PH_W-1:0]    phase;
  logic               frame_wrap;

  assign sys_tick   = (cnt == act_n - P_DIV_W'(1));
  assign bit_rise   = sys_tick && (phase == PH_W'(P_RATIO / 2 - 1));
  assign bit_fall   = sys_tick && (phase == PH_W'(P_RATIO - 1));
  assign frame_wrap = bit_fall && (slot == {SLOT_W{1'b1}});
  assign load_w20   = frame_wrap ? w20_req : act_w20;
  assign bclk       = (phase >= PH_W'(P_RATIO / 2));
  assign lrclk      = slot[SLOT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_n   <= P_DIV_W'(1);
      phase   <= PH_W'(P_RATIO - 1);
      slot    <= {SLOT_W{1'b1}};
      act_w20 <= 1'b0;
    end else begin
      if (sys_tick) cnt <= '0;
      else          cnt <= cnt + P_DIV_W'(1);
      if (sys_tick)
        phase <= (phase == PH_W'(P_RATIO - 1)) ? '0 : phase + PH_W'(1);
      if (bit_fall) slot <= slot + SLOT_W'(1);
      if (frame_wrap) begin
        act_n   <= P_DIV_W'(clamp_div(32'(div_req), P_DIV_MAX));
        act_w20 <= w20_req;
      end
    end
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_n != '0 && act_n <= P_DIV_W'(P_DIV_MAX)); // R1
  AST_CFG_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(act_n) && $stable(act_w20)); // R9
  AST_BCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk) |-> $past(sys_tick)); // R2
  AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrclk) |-> $past(bit_fall)); // R3
endmodule

// File: rtl/aud_tx_ser.sv
module aud_tx_ser
  import aud_link_pkg::*;
#(
  parameter int unsigned P_WORD   = WORD_MAX,
  parameter int unsigned P_SLOT_W = $clog2(2 * HALF_SLOTS),
  localparam int unsigned POS_W   = P_SLOT_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_fall,
  input  logic [P_SLOT_W-1:0] slot,
  input  logic                act_w20,
  input  logic                load_w20,
  input  logic [P_WORD-1:0]   tx_left,
  input  logic [P_WORD-1:0]   tx_right,
  output logic                sdout,
  output logic                tx_ready
);
  logic [P_WORD-1:0]   sh;
  logic [P_SLOT_W-1:0] nslot;
  logic [POS_W-1:0]    npos;
  logic [P_WORD-1:0]   picked;
  logic [P_WORD-1:0]   aligned;
  logic                half_start;
  logic                lsb_done;

  assign nslot      = slot + P_SLOT_W'(1);
  assign npos       = nslot[POS_W-1:0];
  assign half_start = bit_fall && (npos == '0);
  assign lsb_done   = bit_fall && (slot[POS_W-1:0] == POS_W'(word_bits(act_w20)));
  assign picked     = nslot[P_SLOT_W-1] ? tx_right : tx_left;
  assign aligned    = picked << (P_WORD - word_bits(load_w20));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      sdout    <= 1'b0;
      tx_ready <= 1'b0;
    end else begin
      tx_ready <= lsb_done;
      if (half_start) begin
        sh    <= aligned;
        sdout <= 1'b0;
      end else if (bit_fall) begin
        sdout <= sh[P_WORD-1];
        sh    <= {sh[P_WORD-2:0], 1'b0};
      end
    end
  end

  AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdout) |-> $past(bit_fall)); // R6
  AST_GAP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    half_start |=> !sdout); // R4
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_fall && npos > POS_W'(word_bits(act_w20))) |=> !sdout); // R4
  AST_TXRDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready); // R8
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
  import aud_link_pkg::*;
#(
  parameter int unsigned P_WORD   = WORD_MAX,
  parameter int unsigned P_SLOT_W = $clog2(2 * HALF_SLOTS),
  localparam int unsigned POS_W   = P_SLOT_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_rise,
  input  logic [P_SLOT_W-1:0] slot,
  input  logic                act_w20,
  input  logic                sdin,
  output logic [P_WORD-1:0]   rx_data,
  output logic                rx_right,
  output logic                rx_ready
);
  logic [P_WORD-1:0] sh;
  logic [P_WORD-1:0] next_sh;
  logic [P_WORD-1:0] keep_mask;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  nb;
  logic              in_word;
  logic              word_end;

  assign pos       = slot[POS_W-1:0];
  assign nb        = POS_W'(word_bits(act_w20));
  assign in_word   = bit_rise && (pos != '0) && (pos <= nb);
  assign word_end  = in_word && (pos == nb);
  assign next_sh   = {sh[P_WORD-2:0], sdin};
  assign keep_mask = {P_WORD{1'b1}} >> (P_WORD - word_bits(act_w20));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      rx_data  <= '0;
      rx_right <= 1'b0;
      rx_ready <= 1'b0;
    end else begin
      rx_ready <= word_end;
      if (in_word) sh <= next_sh;
      if (word_end) begin
        rx_data  <= next_sh & keep_mask;
        rx_right <= slot[P_SLOT_W-1];
      end
    end
  end

  AST_RXRDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !rx_ready); // R7
  AST_RX_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_ready); // R10
  AST_RX_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !act_w20) |-> rx_data[P_WORD-1:SHORT_BITS] == '0); // R7
endmodule

// File: rtl/aud_link_master.sv
module aud_link_master
  import aud_link_pkg::*;
#(
  parameter int unsigned P_DIV_W   = DIV_W,
  parameter int unsigned P_DIV_MAX = DIV_MAX,
  parameter int unsigned P_WORD    = WORD_MAX,
  localparam int unsigned SLOT_W   = $clog2(2 * HALF_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_DIV_W-1:0] div_n,
  input  logic               word20,
  input  logic [P_WORD-1:0]  tx_left,
  input  logic [P_WORD-1:0]  tx_right,
  input  logic               sdin,
  output logic               sysclk_en,
  output logic               bclk,
  output logic               lrclk,
  output logic               sdout,
  output logic               tx_ready,
  output logic               rx_ready,
  output logic               rx_right,
  output logic [P_WORD-1:0]  rx_data
);
  logic              bit_rise;
  logic              bit_fall;
  logic [SLOT_W-1:0] slot;
  logic              act_w20;
  logic              load_w20;

  aud_clkgen #(.P_DIV_W(P_DIV_W), .P_DIV_MAX(P_DIV_MAX),
               .P_RATIO(BCLK_RATIO), .P_HALF(HALF_SLOTS)) u_clk (
    .clk(clk), .rst_n(rst_n), .div_req(div_n), .w20_req(word20),
    .sys_tick(sysclk_en), .bit_rise(bit_rise), .bit_fall(bit_fall),
    .slot(slot), .act_w20(act_w20), .load_w20(load_w20),
    .bclk(bclk), .lrclk(lrclk));

  aud_tx_ser #(.P_WORD(P_WORD), .P_SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .slot(slot),
    .act_w20(act_w20), .load_w20(load_w20), .tx_left(tx_left),
    .tx_right(tx_right), .sdout(sdout), .tx_ready(tx_ready));

  aud_rx_deser #(.P_WORD(P_WORD), .P_SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .slot(slot),
    .act_w20(act_w20), .sdin(sdin), .rx_data(rx_data),
    .rx_right(rx_right), .rx_ready(rx_ready));

  AST_RX_TX_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_ready)); // R8
endmodule

// File: tb/tb_aud_link_master.sv
`timescale 1ns/1ps
module tb_aud_link_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  div_n = 4'd4;
  logic        word20 = 1'b0;
  logic [19:0] tx_left = '0, tx_right = '0;
  logic        junk_en = 1'b0, junk_slot = 1'b0;
  logic        sysclk_en, bclk, lrclk, sdout, tx_ready, rx_ready, rx_right;
  logic [19:0] rx_data;
  logic        sdin;
  assign sdin = junk_slot ? 1'b1 : sdout;

  aud_link_master dut (
    .clk(clk), .rst_n(rst_n), .div_n(div_n), .word20(word20),
    .tx_left(tx_left), .tx_right(tx_right), .sdin(sdin),
    .sysclk_en(sysclk_en), .bclk(bclk), .lrclk(lrclk), .sdout(sdout),
    .tx_ready(tx_ready), .rx_ready(rx_ready), .rx_right(rx_right),
    .rx_data(rx_data));

  int checks = 0, errors = 0, frames = 0;
  longint cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int limit_n(input int d);
    if (d < 1) return 1;
    if (d > 8) return 8;
    return d;
  endfunction

  function automatic logic [31:0] slot_pattern(input logic [19:0] w, input int nbits);
    logic [31:0] v = '0;
    for (int p = 1; p <= nbits; p++) v[p] = w[nbits - p];
    return v;
  endfunction

  // Inputs as seen by the design at the latest rising edge.
  logic [3:0]  s_div;
  logic        s_w;
  logic [19:0] s_l, s_r;
  always @(posedge clk) begin
    s_div <= div_n; s_w <= word20; s_l <= tx_left; s_r <= tx_right;
  end

  // Frame model and monitor
  bit started = 0;
  logic p_lr = 1'b1, p_bclk = 1'b1, p_sd = 1'b0;
  longint f_start = 0, rx_time = 0;
  int f_n = 1, f_bits = 16, pos = 0, half = 0, tick_cnt = 0, txr_cnt = 0;
  logic [19:0] exp_l = '0, exp_r = '0;
  logic [31:0] cap [2];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_lr && !lrclk) begin
        if (started) begin
          chk(cyc - f_start == 256 * f_n, "R2 R9", "frame length", cyc - f_start, 256 * f_n);
          chk(tick_cnt == 256, "R1", "system strobes per frame", tick_cnt, 256);
          chk(txr_cnt == 2, "R8", "tx_ready pulses per frame", txr_cnt, 2);
          chk(cap[0] == slot_pattern(exp_l, f_bits), "R4 R5", "left slot pattern", cap[0], slot_pattern(exp_l, f_bits));
          chk(cap[1] == slot_pattern(exp_r, f_bits), "R4 R5", "right slot pattern", cap[1], slot_pattern(exp_r, f_bits));
          frames++;
        end
        started  = 1;
        f_start  = cyc;
        f_n      = limit_n(int'(s_div));
        f_bits   = s_w ? 20 : 16;
        exp_l    = s_l;
        tick_cnt = 0;
        txr_cnt  = 0;
        pos      = 0;
        half     = 0;
        cap[0]   = '0;
        cap[1]   = '0;
      end else if (!p_lr && lrclk) begin
        if (started) chk(cyc - f_start == 128 * f_n, "R3", "left half length", cyc - f_start, 128 * f_n);
        half  = 1;
        pos   = 0;
        exp_r = s_r;
      end else if (p_bclk && !bclk) begin
        pos++;
      end
      if (sysclk_en) tick_cnt++;
      if (started && !p_bclk && bclk && pos < 32) cap[half][pos] = sdout;
      if (started && sdout != p_sd)
        chk(p_bclk && !bclk, "R6", "sdout change off falling bclk", 0, 1);
      if (started && rx_ready) begin
        logic [19:0] want;
        want = (half == 1) ? exp_r : exp_l;
        if (f_bits == 16) want[19:16] = 4'h0;
        chk(rx_right == lrclk, "R3", "rx_right vs lrclk", rx_right, lrclk);
        chk(rx_data == want, junk_en ? "R10" : "R7", "received word", rx_data, want);
        rx_time = cyc;
      end
      if (started && tx_ready) begin
        txr_cnt++;
        chk(cyc - rx_time == 2 * f_n, "R8", "tx_ready after rx_ready", cyc - rx_time, 2 * f_n);
      end
      junk_slot = junk_en && started && (pos == 0 || pos > f_bits);
    end
    p_lr = lrclk; p_bclk = bclk; p_sd = sdout;
  end

  // Stimulus table: div, word20, junk, left, right
  localparam int NV = 6;
  localparam logic [45:0] VEC [NV] = '{
    {4'd4,  1'b0, 1'b0, 20'hFBEEF, 20'h94321},
    {4'd6,  1'b1, 1'b0, 20'hA5C3E, 20'h5A3C1},
    {4'd1,  1'b1, 1'b0, 20'h80001, 20'h7FFFE},
    {4'd0,  1'b0, 1'b0, 20'h18000, 20'h00001},
    {4'd12, 1'b1, 1'b1, 20'hFFFFF, 20'h00000},
    {4'd2,  1'b0, 1'b1, 20'h00000, 20'hFFFFF}
  };

  task automatic wait_frames(input int k);
    int f0;
    f0 = frames;
    while (frames < f0 + k) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R11: reset values
    chk(bclk == 1'b1 && lrclk == 1'b1, "R11", "clocks in reset", {bclk, lrclk}, 2'b11);
    chk(sdout == 1'b0 && tx_ready == 1'b0 && rx_ready == 1'b0, "R11", "strobes in reset",
        {sdout, tx_ready, rx_ready}, 0);
    chk(rx_data == 20'h0, "R11", "rx_data in reset", rx_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lrclk == 1'b0, "R11", "left half starts after reset", lrclk, 0);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      div_n    = VEC[i][45:42];
      word20   = VEC[i][41];
      junk_en  = VEC[i][40];
      tx_left  = VEC[i][39:20];
      tx_right = VEC[i][19:0];
      wait_frames(3);
    end
    // R9: change divisor and word length in the middle of a frame
    junk_en = 1'b0;
    div_n = 4'd3; word20 = 1'b1; tx_left = 20'h3C3C3; tx_right = 20'hC3C3C;
    wait_frames(2);
    repeat (40) @(negedge clk);
    div_n = 4'd5; word20 = 1'b0;
    repeat (200) @(negedge clk);
    div_n = 4'd2; word20 = 1'b1;
    wait_frames(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", frames, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule